// File: doc/BRIEF.md
# Combined Read-Modify-Write Execution Unit

This block is the execute step of an 8-bit accumulator processor for the six combined memory opcodes. Each of these opcodes first changes a memory byte and then feeds the changed byte into a second accumulator operation. There are three kinds of first step: a left or right shift or rotate, an increment or a decrement. The second step is an OR, AND, XOR, add, compare or subtract. For each opcode the block produces two results: the byte to be written back to memory, and the new accumulator and N, Z, C, V flags.

The surrounding core supplies these inputs together with a one-cycle start strobe:
- the opcode;
- the byte fetched from memory;
- the accumulator;
- the carry flag;
- the decimal-mode flag.

One clock later the block raises a single-cycle done pulse. At that point the results are valid, and they stay unchanged until the next start.

The add and subtract forms follow packed two-digit decimal rules when the decimal flag is set. V is driven only by those two forms. A separate qualifier output tells the core whether V is to be taken.

Top module: `rmw_exec_unit`

## Requirements
- R1: A start seen on a rising clock edge gives done_o = 1 in the following cycle, and all result outputs are updated at that same edge. Without a start, done_o is 0 and every result output holds its value.
- R2: The operation is chosen by opcode bits [7:5]:
  - 000 is shift-left-then-OR;
  - 001 is rotate-left-then-AND;
  - 010 is shift-right-then-XOR;
  - 011 is rotate-right-then-add;
  - 110 is decrement-then-compare;
  - 111 is increment-then-subtract.
  
  An opcode is accepted only when its low nibble is 0x3, 0x7 or 0xF, or when it is 0xB with bit 4 set. Any other opcode passes through: wb_o is the operand, acc_o is acc_i, C is carry_i, N and Z come from acc_i, and v_wr_o is 0.
- R3: Shift-left-then-OR: C is operand bit 7. The write-back byte is operand<<1 with 0 in bit 0. acc_o is acc_i OR write-back.
- R4: Rotate-left-then-AND: C is operand bit 7. The write-back byte is operand<<1 with the old carry in bit 0. acc_o is acc_i AND write-back.
- R5: Shift-right-then-XOR: C is operand bit 0. The write-back byte is operand>>1 with 0 in bit 7. acc_o is acc_i XOR write-back.
- R6: Rotate-right-then-add, binary mode (decimal_i = 0):
  - The write-back byte r is operand>>1 with the old carry in bit 7.
  - k is old operand bit 0.
  - acc_o = (acc_i + r + k) mod 256.
  - C is set when that sum exceeds 255.
  - V is set when the signed sum falls outside -128..127.
- R7: Rotate-right-then-add, decimal mode (decimal_i = 1):
  - The digit value of a byte is 10 times its high nibble plus its low nibble.
  - s is the sum of the digit values of acc_i and r, plus k.
  - C = (s > 99).
  - acc_o is s mod 100 written as two packed decimal digits.
  - V = (acc_i[7] XOR acc_o[7]) AND (acc_o[7] XOR r[7]).
- R8: Decrement-then-compare:
  - The write-back byte m is (operand - 1) mod 256.
  - acc_o = acc_i.
  - C = (acc_i >= m).
  - N and Z come from the 8-bit difference acc_i - m.
- R9: Increment-then-subtract, binary mode:
  - The write-back byte m is (operand + 1) mod 256.
  - acc_o = (acc_i + ~m + carry_i) mod 256.
  - C is the ninth bit of that sum.
  - V is set when the signed result overflows.
- R10: Increment-then-subtract, decimal mode:
  - acc_o is the packed decimal form of ((digit value of acc_i) - (digit value of m) - (1 - carry_i)) mod 100, taken as a non-negative remainder.
  - C = (acc_i >= m + 1 - carry_i).
  - V = (acc_i[7] XOR acc_o[7]) AND (acc_o[7] XOR m[7]).
- R11: Z is 1 exactly when the result byte is zero, and N is bit 7 of that byte. The result byte is acc_o, except for decrement-then-compare, where it is the difference. v_wr_o is 1 only for the rotate-right-then-add and increment-then-subtract opcodes. When v_wr_o is 0, flag_v_o is 0.
- R12: While rst_n is low, done_o and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Execute strobe, one cycle per opcode |
| opcode_i | input | 8 | Opcode byte |
| operand_i | input | 8 | Byte read from memory |
| acc_i | input | 8 | Current accumulator |
| carry_i | input | 1 | Current carry flag |
| decimal_i | input | 1 | Decimal-mode flag |
| done_o | output | 1 | Result-valid pulse |
| wb_o | output | 8 | Modified byte to write back |
| acc_o | output | 8 | New accumulator |
| flag_n_o | output | 1 | New N |
| flag_z_o | output | 1 | New Z |
| flag_c_o | output | 1 | New C |
| flag_v_o | output | 1 | New V (valid when v_wr_o is 1) |
| v_wr_o | output | 1 | V is updated by this opcode |

## Verification
The bench sweeps every operand byte against a spread of accumulator values, both carry values and both modes, for each of the six operations, and rotates the opcode through all seven accepted columns. It also feeds all 256 opcodes with fixed data.

These sweeps target the following corner cases and the faults they expose:
- **Carry at the shift boundary.** Operands 0x00, 0x01, 0x80 and 0xFF expose a rotate that drops the old carry, or that takes the new carry from the wrong end.
- **Decrement and increment wrap.** 0x00 and 0xFF show whether the write-back byte wraps modulo 256, and whether the compare uses the wrapped byte rather than the original.
- **Decimal boundaries.** Sums above 99, negative decimal differences and non-decimal nibbles catch a missing modulo-100 step or a wrong borrow term.
- **Opcode decode.** The opcode sweep catches a decoder that accepts the 0xB column in even rows, or one that accepts rows 8 to B.

// File: rtl/rmw_exec_pkg.sv
package rmw_exec_pkg;

  localparam int BYTE_W  = 8;
  localparam int NIB_W   = BYTE_W / 2;
  localparam int SUM_W   = BYTE_W + 3;   // signed decimal intermediate
  localparam int DIG_W   = 7;            // 0..99
  localparam int HUNDRED = 100;

  typedef enum logic [2:0] {
    K_SHL_OR  = 3'd0,
    K_ROL_AND = 3'd1,
    K_SHR_XOR = 3'd2,
    K_ROR_ADD = 3'd3,
    K_PASS    = 3'd4,
    K_DEC_CMP = 3'd6,
    K_INC_SUB = 3'd7
  } op_kind_t;

  typedef struct packed {
    logic [BYTE_W-1:0] wb;
    logic [BYTE_W-1:0] acc;
    logic              n;
    logic              z;
    logic              c;
    logic              v;
    logic              vwr;
  } result_t;

  // numeric value of two packed nibbles, each nibble 0..15
  function automatic logic [BYTE_W-1:0] digit_value(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] hi;
    hi = {{NIB_W{1'b0}}, b[BYTE_W-1:NIB_W]};
    return (hi * BYTE_W'(10)) + {{NIB_W{1'b0}}, b[NIB_W-1:0]};
  endfunction

  // non-negative remainder modulo 100 for -200..399
  function automatic logic [DIG_W-1:0] wrap_hundred(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] t;
    t = v;
    for (int i = 0; i < 2; i++)
      if (t < 0) t = t + SUM_W'(HUNDRED);
    for (int i = 0; i < 3; i++)
      if (t >= SUM_W'(HUNDRED)) t = t - SUM_W'(HUNDRED);
    return t[DIG_W-1:0];
  endfunction

  // 0..99 into two packed decimal digits
  function automatic logic [BYTE_W-1:0] to_packed(input logic [DIG_W-1:0] v);
    logic [14:0] prod;
    logic [3:0]  tens;
    logic [DIG_W-1:0] ones;
    prod = {8'b0, v} * 15'd205;
    tens = prod[14:11];
    ones = v - ({3'b0, tens} * DIG_W'(10));
    return {tens, ones[3:0]};
  endfunction

endpackage

// File: rtl/rmw_opdecode.sv
module rmw_opdecode
  import rmw_exec_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output op_kind_t          kind
);
  logic [3:0] col;
  logic [2:0] grp;
  logic       col_ok;
  logic       row_ok;

  assign col = opcode[3:0];
  assign grp = opcode[7:5];

  always_comb begin
    col_ok = (col == 4'h3) || (col == 4'h7) || (col == 4'hF) ||
             ((col == 4'hB) && opcode[4]);
    row_ok = (grp != 3'd4) && (grp != 3'd5);
    if (col_ok && row_ok) kind = op_kind_t'(grp);
    else                  kind = K_PASS;
  end
endmodule

// File: rtl/rmw_memstage.sv
module rmw_memstage
  import rmw_exec_pkg::*;
(
  input  op_kind_t          kind,
  input  logic [BYTE_W-1:0] operand,
  input  logic              cin,
  output logic [BYTE_W-1:0] mod_byte,
  output logic              shift_c
);
  always_comb begin
    mod_byte = operand;
    shift_c  = cin;
    unique case (kind)
      K_SHL_OR:  begin mod_byte = {operand[BYTE_W-2:0], 1'b0}; shift_c = operand[BYTE_W-1]; end
      K_ROL_AND: begin mod_byte = {operand[BYTE_W-2:0], cin};  shift_c = operand[BYTE_W-1]; end
      K_SHR_XOR: begin mod_byte = {1'b0, operand[BYTE_W-1:1]}; shift_c = operand[0]; end
      K_ROR_ADD: begin mod_byte = {cin, operand[BYTE_W-1:1]};  shift_c = operand[0]; end
      K_DEC_CMP: mod_byte = operand - BYTE_W'(1);
      K_INC_SUB: mod_byte = operand + BYTE_W'(1);
      default:   ;
    endcase
  end
endmodule

// File: rtl/rmw_accstage.sv
module rmw_accstage
  import rmw_exec_pkg::*;
(
  input  op_kind_t          kind,
  input  logic [BYTE_W-1:0] mod_byte,
  input  logic              shift_c,
  input  logic [BYTE_W-1:0] acc,
  input  logic              cin,
  input  logic              dec_mode,
  output logic [BYTE_W-1:0] acc_new,
  output logic              n,
  output logic              z,
  output logic              c,
  output logic              v,
  output logic              vwr
);
  logic [BYTE_W-1:0]       addend;
  logic                    add_cin;
  logic [BYTE_W:0]         bin_sum;
  logic                    bin_v;
  logic [BYTE_W:0]         cmp_diff;
  logic [BYTE_W-1:0]       dv_acc;
  logic [BYTE_W-1:0]       dv_mod;
  logic signed [SUM_W-1:0] dec_sum;
  logic signed [SUM_W-1:0] dec_diff;
  logic [BYTE_W-1:0]       dec_add_res;
  logic [BYTE_W-1:0]       dec_sub_res;
  logic                    dec_add_c;
  logic                    dec_sub_c;
  logic                    is_sub;

  assign is_sub  = (kind == K_INC_SUB);
  assign addend  = is_sub ? ~mod_byte : mod_byte;
  assign add_cin = is_sub ? cin : shift_c;
  assign bin_sum = {1'b0, acc} + {1'b0, addend} + {{BYTE_W{1'b0}}, add_cin};
  assign bin_v   = (acc[BYTE_W-1] == addend[BYTE_W-1]) &&
                   (bin_sum[BYTE_W-1] != acc[BYTE_W-1]);
  assign cmp_diff = {1'b0, acc} - {1'b0, mod_byte};

  assign dv_acc   = digit_value(acc);
  assign dv_mod   = digit_value(mod_byte);
  assign dec_sum  = $signed({3'b0, dv_acc}) + $signed({3'b0, dv_mod}) +
                    $signed({{(SUM_W-1){1'b0}}, shift_c});
  assign dec_diff = $signed({3'b0, dv_acc}) - $signed({3'b0, dv_mod}) -
                    $signed({{(SUM_W-1){1'b0}}, ~cin});
  assign dec_add_res = to_packed(wrap_hundred(dec_sum));
  assign dec_sub_res = to_packed(wrap_hundred(dec_diff));
  assign dec_add_c   = (dec_sum > SUM_W'(99));
  assign dec_sub_c   = ({1'b0, acc} >= ({1'b0, mod_byte} + {{BYTE_W{1'b0}}, ~cin}));

  always_comb begin
    acc_new = acc;
    c       = cin;
    v       = 1'b0;
    vwr     = 1'b0;
    unique case (kind)
      K_SHL_OR:  begin acc_new = acc | mod_byte; c = shift_c; end
      K_ROL_AND: begin acc_new = acc & mod_byte; c = shift_c; end
      K_SHR_XOR: begin acc_new = acc ^ mod_byte; c = shift_c; end
      K_DEC_CMP: c = ~cmp_diff[BYTE_W];
      K_ROR_ADD, K_INC_SUB: begin
        vwr = 1'b1;
        if (!dec_mode) begin
          acc_new = bin_sum[BYTE_W-1:0];
          c       = bin_sum[BYTE_W];
          v       = bin_v;
        end else begin
          acc_new = is_sub ? dec_sub_res : dec_add_res;
          c       = is_sub ? dec_sub_c : dec_add_c;
          v       = (acc[BYTE_W-1] ^ acc_new[BYTE_W-1]) &
                    (acc_new[BYTE_W-1] ^ mod_byte[BYTE_W-1]);
        end
      end
      default: ;
    endcase
    if (kind == K_DEC_CMP) begin
      z = (cmp_diff[BYTE_W-1:0] == '0);
      n = cmp_diff[BYTE_W-1];
    end else begin
      z = (acc_new == '0);
      n = acc_new[BYTE_W-1];
    end
  end
endmodule

// File: rtl/rmw_exec_unit.sv
module rmw_exec_unit
  import rmw_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [BYTE_W-1:0] operand_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              carry_i,
  input  logic              decimal_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] wb_o,
  output logic [BYTE_W-1:0] acc_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              v_wr_o
);
  op_kind_t          kind;
  logic [BYTE_W-1:0] mod_byte;
  logic              shift_c;
  result_t           calc;
  result_t           res_q, res_d;
  logic              done_q, done_d;

  rmw_opdecode u_dec (.opcode(opcode_i), .kind(kind));

  rmw_memstage u_mem (
    .kind(kind), .operand(operand_i), .cin(carry_i),
    .mod_byte(mod_byte), .shift_c(shift_c)
  );

  rmw_accstage u_acc (
    .kind(kind), .mod_byte(mod_byte), .shift_c(shift_c), .acc(acc_i),
    .cin(carry_i), .dec_mode(decimal_i), .acc_new(calc.acc),
    .n(calc.n), .z(calc.z), .c(calc.c), .v(calc.v), .vwr(calc.vwr)
  );
  assign calc.wb = mod_byte;

  always_comb begin
    res_d  = res_q;
    done_d = start_i;
    if (start_i) res_d = calc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign done_o   = done_q;
  assign wb_o     = res_q.wb;
  assign acc_o    = res_q.acc;
  assign flag_n_o = res_q.n;
  assign flag_z_o = res_q.z;
  assign flag_c_o = res_q.c;
  assign flag_v_o = res_q.v;
  assign v_wr_o   = res_q.vwr;
endmodule

// File: rtl/rmw_exec_unit_checker.sv
module rmw_exec_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [7:0] opcode_i,
  input logic [7:0] operand_i,
  input logic [7:0] acc_i,
  input logic       carry_i,
  input logic       done_o,
  input logic [7:0] wb_o,
  input logic [7:0] acc_o,
  input logic       flag_c_o,
  input logic       flag_v_o,
  input logic       v_wr_o
);
  logic accepted;
  logic go_shl, go_dec, go_pass, go_vop;

  assign accepted = (opcode_i[7:5] != 3'd4) && (opcode_i[7:5] != 3'd5) &&
                    ((opcode_i[3:0] == 4'h3) || (opcode_i[3:0] == 4'h7) ||
                     (opcode_i[3:0] == 4'hF) || (opcode_i[4:0] == 5'h1B));
  assign go_shl  = start_i && accepted && (opcode_i[7:5] == 3'd0);
  assign go_dec  = start_i && accepted && (opcode_i[7:5] == 3'd6);
  assign go_vop  = start_i && accepted &&
                   ((opcode_i[7:5] == 3'd3) || (opcode_i[7:5] == 3'd7));
  assign go_pass = start_i && !accepted;

  p_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(wb_o) && $stable(acc_o) && $stable(flag_c_o)));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_pass |=> (wb_o == $past(operand_i) && acc_o == $past(acc_i) &&
                 flag_c_o == $past(carry_i) && !v_wr_o));

  p_shl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_shl |=> (wb_o == {$past(operand_i[6:0]), 1'b0} &&
                flag_c_o == $past(operand_i[7]) &&
                acc_o == ($past(acc_i) | wb_o)));

  p_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_dec |=> (acc_o == $past(acc_i) && wb_o == $past(operand_i) - 8'd1 &&
                flag_c_o == ($past(acc_i) >= wb_o)));

  p_vqual_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (v_wr_o == $past(go_vop)));

  p_vmask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !v_wr_o |-> !flag_v_o);
endmodule

bind rmw_exec_unit rmw_exec_unit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
  .operand_i(operand_i), .acc_i(acc_i), .carry_i(carry_i), .done_o(done_o),
  .wb_o(wb_o), .acc_o(acc_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o),
  .v_wr_o(v_wr_o)
);

// File: tb/rmw_exec_unit_test.sv
module rmw_exec_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] opcode_i, operand_i, acc_i;
  logic       carry_i, decimal_i;
  logic       done_o;
  logic [7:0] wb_o, acc_o;
  logic       flag_n_o, flag_z_o, flag_c_o, flag_v_o, v_wr_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] e_wb, e_acc;
  logic       e_n, e_z, e_c, e_v, e_vwr;

  rmw_exec_unit uut (.*);

  always #10 clk = ~clk;

  function automatic int dval(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] pk(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic string tag_of(input logic [7:0] opc, input logic d);
    logic [3:0] lo;
    lo = opc[3:0];
    if (opc[7:5] == 3'd4 || opc[7:5] == 3'd5 ||
        !(lo == 4'h3 || lo == 4'h7 || lo == 4'hF || (lo == 4'hB && opc[4])))
      return "R2";
    case (opc[7:5])
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return d ? "R7" : "R6";
      3'd6: return "R8";
      default: return d ? "R10" : "R9";
    endcase
  endfunction

  task automatic model(input logic [7:0] opc, input logic [7:0] a,
                       input logic [7:0] op, input logic c, input logic d);
    int s;
    logic [8:0] t;
    logic [7:0] diff;
    string tg;
    tg = tag_of(opc, d);
    e_wb = op; e_acc = a; e_c = c; e_v = 0; e_vwr = 0;
    diff = 8'hxx;
    if (tg == "R2") begin
      // pass-through
    end else if (tg == "R3") begin
      e_c = op[7]; e_wb = op << 1; e_acc = a | e_wb;
    end else if (tg == "R4") begin
      e_c = op[7]; e_wb = (op << 1) | {7'd0, c}; e_acc = a & e_wb;
    end else if (tg == "R5") begin
      e_c = op[0]; e_wb = op >> 1; e_acc = a ^ e_wb;
    end else if (tg == "R6" || tg == "R7") begin
      e_wb = (op >> 1) | (c ? 8'h80 : 8'h00);
      e_vwr = 1;
      if (!d) begin
        s = int'(a) + int'(e_wb) + int'(op[0]);
        e_acc = 8'(s);
        e_c = (s > 255);
        s = int'($signed(a)) + int'($signed(e_wb)) + int'(op[0]);
        e_v = (s > 127) || (s < -128);
      end else begin
        s = dval(a) + dval(e_wb) + int'(op[0]);
        e_c = (s > 99);
        e_acc = pk(s % 100);
        e_v = (a[7] ^ e_acc[7]) & (e_acc[7] ^ e_wb[7]);
      end
    end else if (tg == "R8") begin
      e_wb = op - 8'd1;
      e_c = (a >= e_wb);
      diff = a - e_wb;
    end else begin
      e_wb = op + 8'd1;
      e_vwr = 1;
      if (!d) begin
        t = {1'b0, a} + {1'b0, ~e_wb} + {8'd0, c};
        e_acc = t[7:0];
        e_c = t[8];
        s = int'($signed(a)) - int'($signed(e_wb)) - (c ? 0 : 1);
        e_v = (s > 127) || (s < -128);
      end else begin
        s = dval(a) - dval(e_wb) - (c ? 0 : 1);
        s = ((s % 100) + 100) % 100;
        e_acc = pk(s);
        e_c = (int'(a) >= int'(e_wb) + (c ? 0 : 1));
        e_v = (a[7] ^ e_acc[7]) & (e_acc[7] ^ e_wb[7]);
      end
    end
    if (tg == "R8") begin
      e_z = (diff == 8'd0); e_n = diff[7];
    end else begin
      e_z = (e_acc == 8'd0); e_n = e_acc[7];
    end
  endtask

  task automatic compare(input string tg);
    logic [22:0] act, exp;
    act = {done_o, wb_o, acc_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o, v_wr_o};
    exp = {1'b1, e_wb, e_acc, e_n, e_z, e_c, e_v, e_vwr};
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails < 20)
        $display("FAIL %s (R11 flags) opc=%02h actual=%06h expected=%06h",
                 tg, opcode_i, act, exp);
    end
  endtask

  // drive at a negedge, results registered at the next posedge, sample at the next negedge
  task automatic run(input logic [7:0] opc, input logic [7:0] a,
                     input logic [7:0] op, input logic c, input logic d);
    opcode_i = opc; acc_i = a; operand_i = op; carry_i = c; decimal_i = d;
    start_i = 1'b1;
    model(opc, a, op, c, d);
    @(negedge clk);
    compare(tag_of(opc, d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] accs [8];
    logic [3:0] cols [7];
    logic [22:0] held;
    accs = '{8'h00, 8'h01, 8'h09, 8'h45, 8'h7F, 8'h80, 8'h99, 8'hFF};
    cols = '{4'h3, 4'h7, 4'hF, 4'h3, 4'h7, 4'hB, 4'hF};
    rst_n = 1'b0; start_i = 1'b0; opcode_i = 8'h00; operand_i = 8'h00;
    acc_i = 8'h00; carry_i = 1'b0; decimal_i = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if ({done_o, wb_o, acc_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o, v_wr_o} !== 23'd0) begin
      fails++;
      $display("FAIL R12 reset actual=%06h expected=000000",
               {done_o, wb_o, acc_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o, v_wr_o});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3..R10: sweep operand, acc, carry, mode for each operation
    foreach (cols[k]) begin end
    for (int g = 0; g < 8; g++) begin
      if (g == 4 || g == 5) continue;
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          for (int ai = 0; ai < 8; ai++)
            for (int op = 0; op < 256; op++) begin
              int ci;
              ci = op % 7;
              run({3'(g), (ci >= 3) ? 1'b1 : 1'b0, cols[ci]}, accs[ai], 8'(op), c[0], d[0]);
            end
    end

    // R2: every opcode with fixed data
    for (int o = 0; o < 256; o++) run(8'(o), 8'h3C, 8'hA5, 1'b1, 1'b0);

    // R1: no start -> outputs hold, done low
    held = {wb_o, acc_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o, v_wr_o};
    start_i = 1'b0; operand_i = 8'h11; acc_i = 8'h22; opcode_i = 8'h07;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (done_o !== 1'b0 ||
        {wb_o, acc_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o, v_wr_o} !== held) begin
      fails++;
      $display("FAIL R1 hold actual=%0h/%06h expected=0/%06h", done_o,
               {wb_o, acc_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o, v_wr_o}, held);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule